// File: doc/BRIEF.md
# Serial-Bus Write-Only Potentiometer Register Slave

This block is the two-wire serial bus slave that sits in front of a 32-position digital potentiometer controller. It oversamples the bus clock and data lines with the system clock, recognises bus start, repeated start and stop conditions, and matches a 7-bit slave address. The upper four address bits are fixed, the middle two come from a parameter, and the lowest bit is taken from a strap pin. The slave acknowledges by pulling an open-drain data enable high, which drives the line low. It never returns data to the master.

A transaction is an address byte, then a command byte, then one or more data bytes. The command selects one of three operations: load the volatile wiper, load the non-volatile copy register, or copy the wiper into the copy register. Only the first data byte is used, and only its low 5 bits. Setting the eighth address bit high marks the transaction as a no-operation. A no-operation transaction and a transaction to another address leave both registers unchanged.

The controller is built around one state machine with these states: IDLE (bus free), ADDR (shifting in the address byte), ADDR_ACK (driving the address acknowledge), CMD (shifting in the command), CMD_ACK, DATA (shifting in a data byte), DATA_ACK and SKIP (address not matched, or no-operation). Transitions: a stop condition from any state goes to IDLE, and a start condition from any state goes to ADDR. ADDR goes to ADDR_ACK on a match and to SKIP otherwise. ADDR_ACK goes to CMD for a write and to SKIP for a no-operation. CMD goes to CMD_ACK, and CMD_ACK goes to DATA. DATA and DATA_ACK alternate for as long as bytes keep arriving.

Top module: `i2c_pot_slave`

## Requirements
- R1: After reset, the wiper and the copy register both hold mid-scale (16), the write strobe is low and SDA is released.
- R2: The slave answers only the address 0101 followed by the two parameter bits (default 00) and then the level of `addr_sel_i`, sent MSB first. The default write address byte is 0x50 with `addr_sel_i` low and 0x52 with it high. The acknowledge holds SDA low for the whole SCL-high time of the ninth pulse.
- R3: For any other address the slave does not acknowledge, changes no register and ignores the bus until the next start or stop.
- R4: When the eighth address bit is high (no-operation), the address is acknowledged, the bytes that follow are not acknowledged, and no register changes.
- R5: In a write transaction the command byte and every data byte are acknowledged. The acknowledge output changes only while SCL is low.
- R6: Command 0x11 loads the low 5 bits of the first data byte into the wiper.
- R7: Command 0x21 loads the low 5 bits of the first data byte into the copy register and pulses `nv_wr_o` for exactly one clock. The copy register never changes without that pulse.
- R8: Command 0x51 copies the wiper into the copy register as soon as the command byte is received, with one strobe pulse and no data byte needed.
- R9: Any other command value is acknowledged and changes nothing.
- R10: Data bytes after the first one are acknowledged and discarded.
- R11: A repeated start restarts address reception, so a new transaction can follow without a stop.
- R12: A stop before any data byte aborts the transaction with no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND with own drive) |
| addr_sel_i | input | 1 | Strap setting the lowest address bit |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| wiper_o | output | 5 | Volatile wiper position |
| nv_o | output | 5 | Non-volatile copy register |
| nv_wr_o | output | 1 | One-cycle pulse when the copy register is written |

## Verification
The case that is hardest to reach is the SKIP state after a rejected address or a no-operation address, followed by recovery at the next start. From the ports, this state shows only as missing acknowledges. The stimulus therefore sends complete command and data bytes while SKIP is active. With the expected registers held fixed, the per-clock comparison shows that those bytes changed nothing. A start with a matching address then follows at once, without a stop. Repeated starts in the middle of a transaction and stops that abort one are driven in the same way, so that every exit from the state machine is taken at least once.

// File: rtl/pot_pkg.sv
package pot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD,
        ST_CMD_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
    } bus_state_e;

    typedef enum logic [1:0] {OP_NONE, OP_WIPER, OP_NV, OP_COPY} reg_op_e;

    localparam logic [3:0] ADDR_PREFIX   = 4'b0101;
    localparam logic [7:0] CMD_SET_WIPER = 8'h11;
    localparam logic [7:0] CMD_SET_NV    = 8'h21;
    localparam logic [7:0] CMD_COPY      = 8'h51;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-1:0], line_i};
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       clear_i,
    input  logic                       sample_i,
    input  logic                       bit_i,
    output logic [BYTE_W-1:0]          byte_o,
    output logic                       full_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            byte_o <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (sample_i && !full_o) begin
            byte_o <= {byte_o[BYTE_W-2:0], bit_i};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign full_o = (cnt_q == CNT_W'(BYTE_W));
endmodule

// File: rtl/pot_regs.sv
module pot_regs
    import pot_pkg::*;
#(
    parameter int WIPER_W = 5
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  reg_op_e            op_i,
    input  logic [WIPER_W-1:0] data_i,
    output logic [WIPER_W-1:0] wiper_o,
    output logic [WIPER_W-1:0] nv_o,
    output logic               nv_wr_o
);
    localparam logic [WIPER_W-1:0] MID_SCALE = WIPER_W'(1) << (WIPER_W - 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            nv_o    <= MID_SCALE;
            wiper_o <= MID_SCALE;
            nv_wr_o <= 1'b0;
        end else begin
            nv_wr_o <= 1'b0;
            unique case (op_i)
                OP_WIPER: wiper_o <= data_i;
                OP_NV: begin
                    nv_o    <= data_i;
                    nv_wr_o <= 1'b1;
                end
                OP_COPY: begin
                    nv_o    <= wiper_o;
                    nv_wr_o <= 1'b1;
                end
                OP_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_pot_slave.sv
module i2c_pot_slave
    import pot_pkg::*;
#(
    parameter int         WIPER_W     = 5,
    parameter int         SYNC_STAGES = 2,
    parameter logic [1:0] ADDR_MID    = 2'b00
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               addr_sel_i,
    output logic               sda_oe_o,
    output logic [WIPER_W-1:0] wiper_o,
    output logic [WIPER_W-1:0] nv_o,
    output logic               nv_wr_o
);
    localparam int BYTE_W = 8;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det;

    line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

    line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    // Data edges while the clock is steadily high are bus conditions.
    assign start_det = scl_lvl && !scl_rise && sda_fall;
    assign stop_det  = scl_lvl && !scl_rise && sda_rise;

    bus_state_e         state_q, state_d;
    logic               oe_q, oe_d;
    logic               nop_q, nop_d;
    logic               first_q, first_d;
    logic [BYTE_W-1:0]  cmd_q, cmd_d;
    logic               sh_clear, sh_sample, sh_full;
    logic [BYTE_W-1:0]  sh_byte;
    logic [6:0]         own_addr;
    reg_op_e            op;

    assign own_addr = {ADDR_PREFIX, ADDR_MID, addr_sel_i};

    rx_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(sh_clear),
        .sample_i(sh_sample), .bit_i(sda_lvl),
        .byte_o(sh_byte), .full_o(sh_full));

    // State register process.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
            nop_q   <= 1'b0;
            first_q <= 1'b0;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            oe_q    <= oe_d;
            nop_q   <= nop_d;
            first_q <= first_d;
            cmd_q   <= cmd_d;
        end
    end

    // Next-state process.
    always_comb begin
        state_d   = state_q;
        oe_d      = oe_q;
        nop_d     = nop_q;
        first_d   = first_q;
        cmd_d     = cmd_q;
        sh_clear  = 1'b0;
        sh_sample = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (start_det) begin
            state_d  = ST_ADDR;
            oe_d     = 1'b0;
            sh_clear = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR: begin
                    sh_sample = scl_rise;
                    if (scl_fall && sh_full) begin
                        sh_clear = 1'b1;
                        if (sh_byte[7:1] == own_addr) begin
                            state_d = ST_ADDR_ACK;
                            oe_d    = 1'b1;
                            nop_d   = sh_byte[0];
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    oe_d    = 1'b0;
                    state_d = nop_q ? ST_SKIP : ST_CMD;
                end
                ST_CMD: begin
                    sh_sample = scl_rise;
                    if (scl_fall && sh_full) begin
                        sh_clear = 1'b1;
                        cmd_d    = sh_byte;
                        oe_d     = 1'b1;
                        state_d  = ST_CMD_ACK;
                    end
                end
                ST_CMD_ACK: if (scl_fall) begin
                    oe_d    = 1'b0;
                    first_d = 1'b1;
                    state_d = ST_DATA;
                end
                ST_DATA: begin
                    sh_sample = scl_rise;
                    if (scl_fall && sh_full) begin
                        sh_clear = 1'b1;
                        oe_d     = 1'b1;
                        first_d  = 1'b0;
                        state_d  = ST_DATA_ACK;
                    end
                end
                ST_DATA_ACK: if (scl_fall) begin
                    oe_d    = 1'b0;
                    state_d = ST_DATA;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Output process: register operation issued on byte completion.
    always_comb begin
        op = OP_NONE;
        if (!stop_det && !start_det && scl_fall && sh_full) begin
            if (state_q == ST_CMD && sh_byte == CMD_COPY) begin
                op = OP_COPY;
            end else if (state_q == ST_DATA && first_q) begin
                if (cmd_q == CMD_SET_WIPER)   op = OP_WIPER;
                else if (cmd_q == CMD_SET_NV) op = OP_NV;
            end
        end
    end

    pot_regs #(.WIPER_W(WIPER_W)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op),
        .data_i(sh_byte[WIPER_W-1:0]),
        .wiper_o(wiper_o), .nv_o(nv_o), .nv_wr_o(nv_wr_o));

    assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_pot_chk.sv
module i2c_pot_chk #(
    parameter int WIPER_W = 5
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               scl_lvl_i,
    input logic               sda_oe_i,
    input logic [WIPER_W-1:0] wiper_i,
    input logic [WIPER_W-1:0] nv_i,
    input logic               nv_wr_i
);
    localparam logic [WIPER_W-1:0] MID = WIPER_W'(1) << (WIPER_W - 1);

    assert_reset_values_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (wiper_i == MID && nv_i == MID && !nv_wr_i && !sda_oe_i));

    assert_ack_scl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sda_oe_i) |-> !scl_lvl_i);

    assert_wiper_in_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(wiper_i) |-> sda_oe_i);

    assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nv_wr_i |=> !nv_wr_i);

    assert_nv_needs_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(nv_i) |-> nv_wr_i);
endmodule

bind i2c_pot_slave i2c_pot_chk #(.WIPER_W(WIPER_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_lvl_i(scl_lvl),
    .sda_oe_i(sda_oe_o), .wiper_i(wiper_o), .nv_i(nv_o), .nv_wr_i(nv_wr_o));

// File: tb/tb_i2c_pot_slave.sv
module tb_i2c_pot_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 10;

    logic clk = 1'b0, rst_ni = 1'b0, scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0;
    logic sda_oe, nv_wr;
    logic [4:0] wiper, nv;
    wire sda_bus = sda_m & ~sda_oe;

    int n_cmp = 0, n_bad = 0;
    int exp_wiper = 16, exp_nv = 16, exp_str = 0, seen_str = 0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_pot_slave dut (
        .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel_i(sel), .sda_oe_o(sda_oe), .wiper_o(wiper),
        .nv_o(nv), .nv_wr_o(nv_wr));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-clock reference comparison (R6 R7 R8 R9 R10 hold between updates).
    always @(negedge clk) begin
        if (cmp_en) begin
            check(wiper == 5'(exp_wiper), "R6", "wiper vs model", wiper, exp_wiper);
            check(nv == 5'(exp_nv), "R7", "nv vs model", nv, exp_nv);
        end
    end
    always @(posedge clk) if (rst_ni && nv_wr) seen_str++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
        end else begin
            sda_m = 1'b1; tick(HALF);
        end
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl_m = 1'b1; tick(HALF);
            scl_m = 1'b0; tick(2);
        end
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF/2);
        check(sda_bus == !exp_ack, req, $sformatf("ack level for byte %02h", b),
              sda_bus, !exp_ack);
        tick(HALF/2);
        scl_m = 1'b0; tick(2);
    endtask

    // Write transaction whose first data byte is an update the model applies.
    task automatic wr_txn(input logic [7:0] addr, input logic [7:0] cmd,
                          input logic [7:0] data, input string req);
        bus_start();
        send_byte(addr, 1'b1, "R2");
        send_byte(cmd, 1'b1, "R5");
        cmp_en = 1'b0;
        send_byte(data, 1'b1, req);
        if (cmd == 8'h11) exp_wiper = data & 8'h1F;
        if (cmd == 8'h21) begin exp_nv = data & 8'h1F; exp_str++; end
        cmp_en = 1'b1;
        bus_stop();
    endtask

    initial begin
        tick(5);
        check(wiper == 5'd16, "R1", "reset wiper", wiper, 16);
        check(nv == 5'd16, "R1", "reset nv", nv, 16);
        check(!sda_oe && !nv_wr, "R1", "reset oe/strobe", {sda_oe, nv_wr}, 0);
        rst_ni = 1'b1; tick(3);
        check(wiper == 5'd16 && nv == 5'd16, "R1", "after release", wiper, 16);
        cmp_en = 1'b1;

        wr_txn(8'h50, 8'h11, 8'h07, "R6");
        wr_txn(8'h50, 8'h11, 8'hFF, "R6");
        wr_txn(8'h50, 8'h21, 8'h0A, "R7");
        check(seen_str == exp_str, "R7", "strobe count", seen_str, exp_str);

        // R8: copy takes effect on the command byte alone
        bus_start();
        send_byte(8'h50, 1'b1, "R2");
        cmp_en = 1'b0;
        send_byte(8'h51, 1'b1, "R8");
        exp_nv = exp_wiper; exp_str++;
        cmp_en = 1'b1;
        bus_stop();
        check(seen_str == exp_str, "R8", "copy strobe count", seen_str, exp_str);

        // R10: further data bytes acked and dropped
        bus_start();
        send_byte(8'h50, 1'b1, "R2");
        send_byte(8'h11, 1'b1, "R5");
        cmp_en = 1'b0;
        send_byte(8'h03, 1'b1, "R10");
        exp_wiper = 3;
        cmp_en = 1'b1;
        send_byte(8'h09, 1'b1, "R10");
        send_byte(8'h1E, 1'b1, "R10");
        bus_stop();

        // R9: unknown command
        bus_start();
        send_byte(8'h50, 1'b1, "R2");
        send_byte(8'h33, 1'b1, "R9");
        send_byte(8'h05, 1'b1, "R9");
        bus_stop();

        // R4: no-operation address
        bus_start();
        send_byte(8'h51, 1'b1, "R4");
        send_byte(8'h11, 1'b0, "R4");
        send_byte(8'h04, 1'b0, "R4");
        bus_stop();

        // R3: prefix mismatch
        bus_start();
        send_byte(8'h60, 1'b0, "R3");
        send_byte(8'h11, 1'b0, "R3");
        send_byte(8'h02, 1'b0, "R3");
        bus_stop();

        // R3: low-bit mismatch, recovery on a start without stop
        bus_start();
        send_byte(8'h52, 1'b0, "R3");
        send_byte(8'h21, 1'b0, "R3");
        bus_start();
        send_byte(8'h50, 1'b1, "R3");
        send_byte(8'h11, 1'b1, "R5");
        cmp_en = 1'b0;
        send_byte(8'h0C, 1'b1, "R3");
        exp_wiper = 12;
        cmp_en = 1'b1;
        bus_stop();

        // R11: repeated start after a command byte
        bus_start();
        send_byte(8'h50, 1'b1, "R2");
        send_byte(8'h21, 1'b1, "R11");
        bus_start();
        send_byte(8'h50, 1'b1, "R11");
        send_byte(8'h11, 1'b1, "R11");
        cmp_en = 1'b0;
        send_byte(8'h06, 1'b1, "R11");
        exp_wiper = 6;
        cmp_en = 1'b1;
        bus_stop();

        // R12: stop after the command byte
        bus_start();
        send_byte(8'h50, 1'b1, "R2");
        send_byte(8'h11, 1'b1, "R12");
        bus_stop();
        check(wiper == 5'(exp_wiper), "R12", "wiper after abort", wiper, exp_wiper);

        // R2: strap high moves the address
        sel = 1'b1; tick(4);
        wr_txn(8'h52, 8'h11, 8'h19, "R2");
        bus_start();
        send_byte(8'h50, 1'b0, "R2");
        bus_stop();

        tick(20);
        check(seen_str == exp_str, "R7", "final strobe count", seen_str, exp_str);
        check(!sda_oe, "R5", "bus released at end", sda_oe, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule